// File: doc/BRIEF.md
# Bus Hold and External DMA Arbiter

This block decides who drives a processor's external address, data and memory-control lines: the core or an outside master. An outside device pulls an active-low hold input to ask for the bus. The arbiter waits until the core is between bus cycles. It then floats the core's drivers for one cycle and only after that drives the hold acknowledge low. When the hold input is removed, the acknowledge rises first, and the core's drivers come back one cycle later.

While the hold is granted, two pins take on a second job. The bus-request pin is no longer driven. It becomes an input on which the outside master asks for access to the core's single-access on-chip RAM. The instruction-acquisition pin stops reporting fetches and instead acknowledges that request. Outside the hold, bus-request is an output that flags a core access to global data memory, and that access waits for the ready input. An active-low output-disable input floats every managed output, whatever the arbiter state is.

The block contains a four-state ownership sequencer, a qualifier that filters the DMA request, and pin-control logic that produces the drive values and tri-state enables.

Top module: `bus_hold_arb`

## Requirements
- R1: After reset the core owns the bus: `holda_n_out`=1, `dma_req`=0, `core_hold`=0 while `hold_req_n`=1, and with `off_n`=1 the outputs `bus_oe`, `we_oe` and `br_oe` are 1.
- R2: The arbiter leaves core ownership only on a clock edge where `hold_req_n`=0 and `core_busy`=0. While `core_busy`=1, a pending hold is not granted.
- R3: After the grant edge, the bus drivers (`bus_oe`, `we_oe`, `br_oe`) are 0 for one full cycle with `holda_n_out` still 1. `holda_n_out` goes to 0 on the following edge. Whenever `holda_n_out`=0, `bus_oe`=0 and `we_oe`=0.
- R4: During the grant, the first clock edge that samples `hold_req_n`=1 drives `holda_n_out` to 1. `bus_oe` returns to 1 on the next edge (when `off_n`=1).
- R5: While the core owns the bus: `br_oe`=`off_n`, `br_n_out`=NOT `core_gdm_req`, and `gdm_go`=`core_gdm_req` AND `ready`. In every other state `gdm_go`=0.
- R6: `dma_req` is 1 only during the grant, after `br_n_in` has been sampled 0 on two consecutive clock edges. It falls in the cycle after an edge that samples `br_n_in`=1, and it falls at once when the grant ends. A single low sample never raises it.
- R7: `iaq_n_out` equals NOT `iaq_core` while the core owns the bus. It equals NOT `dma_req` during the grant. It is 1 in the two transition states.
- R8: With `off_n`=0, the outputs `br_oe`, `iaq_oe`, `holda_oe`, `we_oe`, `clk_oe` and `bus_oe` are all 0, and the arbiter state still advances.
- R9: `core_hold` is 1 whenever the core does not own the bus. It is also 1 in the ownership state while `hold_req_n`=0 and `core_busy`=0, so that no new core access starts on the grant edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | External hold request, active low |
| off_n | input | 1 | Global output disable, active low |
| core_busy | input | 1 | Core bus cycle in progress; a grant is not allowed |
| core_hold | output | 1 | Tells the core not to start a bus cycle |
| core_gdm_req | input | 1 | Core requests a global data memory access |
| ready | input | 1 | Global memory is available |
| gdm_go | output | 1 | Global access may proceed |
| iaq_core | input | 1 | Core has an instruction address on the bus |
| we_core_n | input | 1 | Core write strobe, active low |
| br_n_in | input | 1 | Sampled value of the bus-request pad |
| br_n_out | output | 1 | Bus-request drive value, active low |
| br_oe | output | 1 | Bus-request drive enable |
| iaq_n_out | output | 1 | Instruction-acquisition / DMA acknowledge, active low |
| iaq_oe | output | 1 | Instruction-acquisition drive enable |
| holda_n_out | output | 1 | Hold acknowledge, active low |
| holda_oe | output | 1 | Hold acknowledge drive enable |
| we_n_out | output | 1 | Write-enable drive value, active low |
| we_oe | output | 1 | Write-enable drive enable |
| clk_oe | output | 1 | Clock output drive enable |
| bus_oe | output | 1 | Address/data drive enable |
| dma_req | output | 1 | Qualified DMA request to the on-chip RAM |

## Verification
Hold requests are tried both against an idle core and against a core that stays busy for several cycles. The first case checks that the grant needs both conditions; the second checks that the grant waits for the cycle boundary. One request is withdrawn during the float cycle, which exposes any shortcut through the sequencer. During the grant, `br_n_in` is driven with a single-cycle low pulse, a two-cycle low run and a long low run. These show whether the qualifier filters glitches, when it first fires and how it drops. Output-disable pulses are applied both in ownership and in grant, to show that floating is independent of state and does not disturb the sequencer.

// File: rtl/bha_pkg.sv
package bha_pkg;
  typedef enum logic [1:0] {
    ST_OWN   = 2'd0,
    ST_FLOAT = 2'd1,
    ST_GRANT = 2'd2,
    ST_REL   = 2'd3
  } arb_st_e;
endpackage

// File: rtl/bha_hold_fsm.sv
module bha_hold_fsm
  import bha_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold_req_n,
  input  logic    core_busy,
  output arb_st_e st
);

  arb_st_e st_d;

  // next-state
  always_comb begin
    st_d = st;
    unique case (st)
      ST_OWN:   if (!hold_req_n && !core_busy) st_d = ST_FLOAT;
      ST_FLOAT: st_d = ST_GRANT;
      ST_GRANT: if (hold_req_n) st_d = ST_REL;
      ST_REL:   st_d = ST_OWN;
      default:  st_d = ST_OWN;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OWN;
    else        st <= st_d;
  end

  // R2: floating starts only from a sampled request at a cycle boundary
  a_r2_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLOAT) |-> ($past(st) == ST_OWN && !$past(hold_req_n) && !$past(core_busy)));

  // R3: grant is always preceded by the float cycle
  a_r3_float_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GRANT) |-> ($past(st) == ST_FLOAT || $past(st) == ST_GRANT));

  // R4: a removed request ends the grant on the next edge
  a_r4_release_next: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GRANT && hold_req_n) |=> (st == ST_REL));

endmodule

// File: rtl/bha_dma_qual.sv
module bha_dma_qual #(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_grant,
  input  logic br_n_in,
  output logic dma_req
);

  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] CMAX = CW'(QUAL);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // clock enable: the counter moves only while it is counting or must clear
  assign cnt_en = (cnt_q != '0) || (in_grant && !br_n_in);

  always_comb begin
    cnt_d = cnt_q;
    if (!in_grant || br_n_in) cnt_d = '0;
    else if (cnt_q != CMAX)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign dma_req = in_grant && (cnt_q == CMAX);

  // R6: a new DMA request always follows a low sample of the pin
  a_r6_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> !$past(br_n_in));

  // R6: no DMA request outside the grant
  a_r6_only_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> in_grant);

endmodule

// File: rtl/bha_pin_ctrl.sv
module bha_pin_ctrl
  import bha_pkg::*;
(
  input  arb_st_e st,
  input  logic    off_n,
  input  logic    hold_req_n,
  input  logic    core_busy,
  input  logic    core_gdm_req,
  input  logic    ready,
  input  logic    iaq_core,
  input  logic    we_core_n,
  input  logic    dma_req,
  output logic    core_hold,
  output logic    gdm_go,
  output logic    br_n_out,
  output logic    br_oe,
  output logic    iaq_n_out,
  output logic    iaq_oe,
  output logic    holda_n_out,
  output logic    holda_oe,
  output logic    we_n_out,
  output logic    we_oe,
  output logic    clk_oe,
  output logic    bus_oe
);

  logic own, grant;

  assign own   = (st == ST_OWN);
  assign grant = (st == ST_GRANT);

  // core side
  assign core_hold = !own || (!hold_req_n && !core_busy);
  assign gdm_go    = own && core_gdm_req && ready;

  // pin drive values
  assign br_n_out    = !core_gdm_req;
  assign we_n_out    = we_core_n;
  assign holda_n_out = !grant;

  always_comb begin
    unique case (st)
      ST_OWN:   iaq_n_out = !iaq_core;
      ST_GRANT: iaq_n_out = !dma_req;
      default:  iaq_n_out = 1'b1;
    endcase
  end

  // tri-state enables
  assign bus_oe   = off_n && own;
  assign we_oe    = off_n && own;
  assign br_oe    = off_n && own;
  assign iaq_oe   = off_n;
  assign holda_oe = off_n;
  assign clk_oe   = off_n;

endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
  import bha_pkg::*;
#(
  parameter int DMA_QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic off_n,
  input  logic core_busy,
  output logic core_hold,
  input  logic core_gdm_req,
  input  logic ready,
  output logic gdm_go,
  input  logic iaq_core,
  input  logic we_core_n,
  input  logic br_n_in,
  output logic br_n_out,
  output logic br_oe,
  output logic iaq_n_out,
  output logic iaq_oe,
  output logic holda_n_out,
  output logic holda_oe,
  output logic we_n_out,
  output logic we_oe,
  output logic clk_oe,
  output logic bus_oe,
  output logic dma_req
);

  arb_st_e st;

  bha_hold_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req_n (hold_req_n),
    .core_busy  (core_busy),
    .st         (st)
  );

  bha_dma_qual #(.QUAL(DMA_QUAL)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_grant (st == ST_GRANT),
    .br_n_in  (br_n_in),
    .dma_req  (dma_req)
  );

  bha_pin_ctrl u_pins (
    .st           (st),
    .off_n        (off_n),
    .hold_req_n   (hold_req_n),
    .core_busy    (core_busy),
    .core_gdm_req (core_gdm_req),
    .ready        (ready),
    .iaq_core     (iaq_core),
    .we_core_n    (we_core_n),
    .dma_req      (dma_req),
    .core_hold    (core_hold),
    .gdm_go       (gdm_go),
    .br_n_out     (br_n_out),
    .br_oe        (br_oe),
    .iaq_n_out    (iaq_n_out),
    .iaq_oe       (iaq_oe),
    .holda_n_out  (holda_n_out),
    .holda_oe     (holda_oe),
    .we_n_out     (we_n_out),
    .we_oe        (we_oe),
    .clk_oe       (clk_oe),
    .bus_oe       (bus_oe)
  );

  // R3: acknowledge low only with the core's drivers floated
  a_r3_holda_implies_float: assert property (@(posedge clk) disable iff (!rst_n)
    !holda_n_out |-> (!bus_oe && !we_oe));

  // R4: drivers return only after the acknowledge has already been high
  a_r4_drive_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) && $past(off_n) |-> $past(holda_n_out));

  // R8: output disable floats every managed output
  a_r8_off_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !off_n |-> !(br_oe || iaq_oe || holda_oe || we_oe || clk_oe || bus_oe));

  // R7: acknowledge pin follows the DMA request during the grant
  a_r7_iaq_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && off_n) |-> (!iaq_n_out && iaq_oe));

  // R9: the core is held whenever the acknowledge is active
  a_r9_core_held: assert property (@(posedge clk) disable iff (!rst_n)
    !holda_n_out |-> core_hold);

endmodule

// File: tb/bus_hold_arb_test.sv
`timescale 1ns/1ps
module bus_hold_arb_test;

  logic clk = 1'b0;
  logic rst_n, hold_req_n, off_n, core_busy, core_gdm_req, ready, iaq_core, we_core_n, br_n_in;
  logic core_hold, gdm_go, br_n_out, br_oe, iaq_n_out, iaq_oe, holda_n_out, holda_oe;
  logic we_n_out, we_oe, clk_oe, bus_oe, dma_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state: 0 own, 1 float, 2 grant, 3 release
  int m_st = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  bus_hold_arb uut (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .off_n(off_n),
    .core_busy(core_busy), .core_hold(core_hold), .core_gdm_req(core_gdm_req),
    .ready(ready), .gdm_go(gdm_go), .iaq_core(iaq_core), .we_core_n(we_core_n),
    .br_n_in(br_n_in), .br_n_out(br_n_out), .br_oe(br_oe), .iaq_n_out(iaq_n_out),
    .iaq_oe(iaq_oe), .holda_n_out(holda_n_out), .holda_oe(holda_oe),
    .we_n_out(we_n_out), .we_oe(we_oe), .clk_oe(clk_oe), .bus_oe(bus_oe),
    .dma_req(dma_req)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // model update on the clock edge from the inputs held across it
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st  = 0;
      m_cnt = 0;
    end else begin
      if (m_st != 2 || br_n_in) m_cnt = 0;
      else if (m_cnt < 2)       m_cnt = m_cnt + 1;
      case (m_st)
        0: if (!hold_req_n && !core_busy) m_st = 1;
        1: m_st = 2;
        2: if (hold_req_n) m_st = 3;
        default: m_st = 0;
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic own, grant, e_dma, e_iaq;
      own   = (m_st == 0);
      grant = (m_st == 2);
      e_dma = grant && (m_cnt == 2);
      e_iaq = own ? !iaq_core : (grant ? !e_dma : 1'b1);
      chk("R2", "core_hold/grant path", core_hold, !own || (!hold_req_n && !core_busy));
      chk("R3", "bus_oe", bus_oe, off_n && own);
      chk("R3", "we_oe", we_oe, off_n && own);
      chk("R4", "holda_n_out", holda_n_out, !grant);
      chk("R5", "br_oe", br_oe, off_n && own);
      chk("R5", "br_n_out", br_n_out, !core_gdm_req);
      chk("R5", "gdm_go", gdm_go, own && core_gdm_req && ready);
      chk("R6", "dma_req", dma_req, e_dma);
      chk("R7", "iaq_n_out", iaq_n_out, e_iaq);
      chk("R8", "iaq_oe", iaq_oe, off_n);
      chk("R8", "holda_oe", holda_oe, off_n);
      chk("R8", "clk_oe", clk_oe, off_n);
      chk("R9", "we_n_out", we_n_out, we_core_n);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; hold_req_n = 1'b1; off_n = 1'b1; core_busy = 1'b0;
    core_gdm_req = 1'b0; ready = 1'b0; iaq_core = 1'b0; we_core_n = 1'b1; br_n_in = 1'b1;
    step(3);
    // R1: reset state
    chk("R1", "holda_n_out at reset", holda_n_out, 1'b1);
    chk("R1", "bus_oe at reset", bus_oe, 1'b1);
    chk("R1", "dma_req at reset", dma_req, 1'b0);
    chk("R1", "core_hold at reset", core_hold, 1'b0);
    rst_n = 1'b1;
    step(2);
    // R5 / R7: core-owned traffic patterns
    core_gdm_req = 1'b1; step(2);
    ready = 1'b1; step(1);
    iaq_core = 1'b1; we_core_n = 1'b0; step(1);
    core_gdm_req = 1'b0; ready = 1'b0; iaq_core = 1'b0; we_core_n = 1'b1; step(1);
    // R2: hold blocked by a busy core
    core_busy = 1'b1; hold_req_n = 1'b0; step(3);
    chk("R2", "no grant while busy", holda_n_out, 1'b1);
    core_busy = 1'b0; step(1);
    chk("R3", "float cycle bus_oe", bus_oe, 1'b0);
    chk("R3", "float cycle holda", holda_n_out, 1'b1);
    step(1);
    chk("R3", "holda after float", holda_n_out, 1'b0);
    // R6: single low pulse, then a two-cycle run, then a long run
    br_n_in = 1'b0; step(1); br_n_in = 1'b1; step(2);
    chk("R6", "single low sample ignored", dma_req, 1'b0);
    br_n_in = 1'b0; step(2);
    chk("R6", "two low samples raise", dma_req, 1'b1);
    chk("R7", "ack during grant", iaq_n_out, 1'b0);
    br_n_in = 1'b1; step(1);
    chk("R6", "drops after high sample", dma_req, 1'b0);
    br_n_in = 1'b0; step(4);
    // R8: output disable during grant
    off_n = 1'b0; step(2); off_n = 1'b1; step(1);
    // R4: release while DMA is active
    hold_req_n = 1'b1; step(1);
    chk("R4", "holda released", holda_n_out, 1'b1);
    chk("R6", "dma ends with grant", dma_req, 1'b0);
    chk("R4", "bus still floated", bus_oe, 1'b0);
    step(1);
    chk("R4", "bus re-enabled", bus_oe, 1'b1);
    br_n_in = 1'b1; step(2);
    // request withdrawn during the float cycle
    hold_req_n = 1'b0; step(1); hold_req_n = 1'b1; step(4);
    // R8: output disable while the core owns the bus
    core_gdm_req = 1'b1; off_n = 1'b0; step(1);
    chk("R8", "br floated", br_oe, 1'b0);
    off_n = 1'b1; core_gdm_req = 1'b0; step(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule